// File: doc/BRIEF.md
# Interrupt-capable general-purpose I/O port

This block is a register-mapped general-purpose I/O unit. It has one narrow port whose pins can raise interrupts and a set of wider plain ports without interrupt logic. Every port has a drive-value register, an output-enable register and a read-only view of the pin levels. The pin levels pass through a two-flop synchronizer before software or the trigger logic sees them. The block drives the pad-side drive and enable signals directly; the pad cells are outside it.

Each pin of the narrow port has its own trigger mode. The mode can follow a level, follow a rising, falling or any edge, be forced on, or be switched off. A trigger sets that pin's pending latch. Software reads the pending bits through a mask, and it clears them by writing ones to an acknowledge address. The block has a single interrupt output, which is high while any unmasked pending bit is set.

Accesses are single-cycle. A write takes effect on the clock edge where `bus_sel` and `bus_wr` are both high. A read returns `bus_rdata` combinationally from `bus_addr`.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register is 0. All pins are inputs (enable 0), every trigger mode is off, and `irq` is low.
- R2: The drive register drives `*_pin_out` and the enable register drives `*_pin_oe`, where 1 means output. Both read back unchanged. Writes to read-only addresses change nothing. The narrow-port addresses are: 0 drive, 1 pin levels, 2 enable, 3 trigger modes, 4 mask, 5 masked status, 6 acknowledge.
- R3: A read of the pin-level address returns the pin value as it stood two clock edges before.
- R4: The mode of pin i sits at bits 3i+2..3i of address 3. The codes are: 0 off, 1 level high, 2 level low, 3 forced, 4 rising, 5 falling, 6 any edge. Code 7 acts as off.
- R5: In the level modes, a pin whose synchronized level matches the mode sets its pending bit. Right after an acknowledge the bit reads 0, and it is set again one cycle later for as long as the level holds.
- R6: In forced mode the pending bit is 1 on every cycle, including the cycle right after an acknowledge.
- R7: In the edge modes, a matching change of the synchronized level sets the pending bit. The bit then stays set, even after the pin returns, until it is acknowledged.
- R8: Address 5 reads the pending bits ANDed with the mask at address 4. `irq` is the OR of those bits.
- R9: Writing a 1 to a bit at address 6 clears that pending bit. Bits written as 0 keep their state, and address 6 reads as 0.
- R10: An edge trigger that lands on the same cycle as an acknowledge of its pin leaves the pending bit set.
- R11: Plain port k has its drive register at address 8+4k, its pin levels at 9+4k and its enable register at 10+4k. It has the same synchronized input as the narrow port and no interrupt logic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational |
| ipin_in | input | IRQ_W | Narrow-port pin levels |
| ipin_out | output | IRQ_W | Narrow-port drive values |
| ipin_oe | output | IRQ_W | Narrow-port output enables |
| ppin_in | input | NUM_PLAIN*PLAIN_W | Plain-port pin levels, port k at slice k |
| ppin_out | output | NUM_PLAIN*PLAIN_W | Plain-port drive values |
| ppin_oe | output | NUM_PLAIN*PLAIN_W | Plain-port output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The bench runs all eight mode codes against several pairs of before and after pin patterns. It reads the status right after the acknowledge edge and again one cycle later. If the design gave the acknowledge priority over forced mode, the forced bits would show 0 right after the acknowledge. If level modes never re-triggered, the second read would come back empty. Another case places a rising edge on the very edge that acknowledges its pin; a design that let the clear win would lose that interrupt. The bench also checks the synchronizer latency one edge at a time, so a single-flop or three-flop path reads wrong. It checks partial acknowledges and masks for bits that were disturbed or leaked.

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int IRQ_W     = 8,
  parameter int PLAIN_W   = 18,
  parameter int NUM_PLAIN = 4,
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_sel,
  input  logic                          bus_wr,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [DATA_W-1:0]             bus_wdata,
  output logic [DATA_W-1:0]             bus_rdata,
  input  logic [IRQ_W-1:0]              ipin_in,
  output logic [IRQ_W-1:0]              ipin_out,
  output logic [IRQ_W-1:0]              ipin_oe,
  input  logic [NUM_PLAIN*PLAIN_W-1:0]  ppin_in,
  output logic [NUM_PLAIN*PLAIN_W-1:0]  ppin_out,
  output logic [NUM_PLAIN*PLAIN_W-1:0]  ppin_oe,
  output logic                          irq
);
  localparam int CFG_W        = 3 * IRQ_W;
  localparam int PLAIN_BASE   = 8;
  localparam int PLAIN_STRIDE = 4;
  localparam logic [ADDR_W-1:0] A_DOUT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DIN  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_OE   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(6);

  logic              wr;
  logic [IRQ_W-1:0]  dout_q, oe_q, mask_q, pend_q, pend_d, ack;
  logic [IRQ_W-1:0]  s1_q, s2_q, s3_q;
  logic [CFG_W-1:0]  cfg_q;
  logic [DATA_W-1:0] irq_rd;
  logic [DATA_W-1:0] p_rd [NUM_PLAIN];

  assign wr  = bus_sel & bus_wr;
  assign ack = (wr && bus_addr == A_ACK) ? bus_wdata[IRQ_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0; oe_q <= '0; mask_q <= '0; cfg_q <= '0; pend_q <= '0;
      s1_q <= '0; s2_q <= '0; s3_q <= '0;
    end else begin
      if (wr && bus_addr == A_DOUT) dout_q <= bus_wdata[IRQ_W-1:0];
      if (wr && bus_addr == A_OE)   oe_q   <= bus_wdata[IRQ_W-1:0];
      if (wr && bus_addr == A_MASK) mask_q <= bus_wdata[IRQ_W-1:0];
      if (wr && bus_addr == A_CFG)  cfg_q  <= bus_wdata[CFG_W-1:0];
      s1_q   <= ipin_in;
      s2_q   <= s1_q;
      s3_q   <= s2_q;
      pend_q <= pend_d;
    end
  end

  for (genvar g = 0; g < IRQ_W; g++) begin : g_pin
    logic [2:0] mode;
    logic rise, fall, lvl, edg, frc;
    assign mode = cfg_q[3*g +: 3];
    assign rise = s2_q[g] & ~s3_q[g];
    assign fall = ~s2_q[g] & s3_q[g];
    always_comb begin
      lvl = 1'b0; edg = 1'b0; frc = 1'b0;
      case (mode)
        3'd1: lvl = s2_q[g];
        3'd2: lvl = ~s2_q[g];
        3'd3: frc = 1'b1;
        3'd4: edg = rise;
        3'd5: edg = fall;
        3'd6: edg = rise | fall;
        default: ;
      endcase
    end
    assign pend_d[g] = frc | edg | (~ack[g] & (pend_q[g] | lvl));
  end

  assign ipin_out = dout_q;
  assign ipin_oe  = oe_q;
  assign irq      = |(pend_q & mask_q);

  for (genvar k = 0; k < NUM_PLAIN; k++) begin : g_plain
    localparam logic [ADDR_W-1:0] B_DOUT = ADDR_W'(PLAIN_BASE + PLAIN_STRIDE*k);
    localparam logic [ADDR_W-1:0] B_DIN  = ADDR_W'(PLAIN_BASE + PLAIN_STRIDE*k + 1);
    localparam logic [ADDR_W-1:0] B_OE   = ADDR_W'(PLAIN_BASE + PLAIN_STRIDE*k + 2);
    logic [PLAIN_W-1:0] dq, oq, t1, t2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dq <= '0; oq <= '0; t1 <= '0; t2 <= '0;
      end else begin
        if (wr && bus_addr == B_DOUT) dq <= bus_wdata[PLAIN_W-1:0];
        if (wr && bus_addr == B_OE)   oq <= bus_wdata[PLAIN_W-1:0];
        t1 <= ppin_in[k*PLAIN_W +: PLAIN_W];
        t2 <= t1;
      end
    end
    assign ppin_out[k*PLAIN_W +: PLAIN_W] = dq;
    assign ppin_oe[k*PLAIN_W +: PLAIN_W]  = oq;
    assign p_rd[k] = (bus_addr == B_DOUT) ? DATA_W'(dq) :
                     (bus_addr == B_DIN)  ? DATA_W'(t2) :
                     (bus_addr == B_OE)   ? DATA_W'(oq) : '0;
  end

  always_comb begin
    case (bus_addr)
      A_DOUT:  irq_rd = DATA_W'(dout_q);
      A_DIN:   irq_rd = DATA_W'(s2_q);
      A_OE:    irq_rd = DATA_W'(oe_q);
      A_CFG:   irq_rd = DATA_W'(cfg_q);
      A_MASK:  irq_rd = DATA_W'(mask_q);
      A_STAT:  irq_rd = DATA_W'(pend_q & mask_q);
      default: irq_rd = '0;
    endcase
    bus_rdata = irq_rd;
    for (int k = 0; k < NUM_PLAIN; k++) bus_rdata = bus_rdata | p_rd[k];
  end
endmodule

module gpio_irq_port_chk #(
  parameter int IRQ_W  = 8,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_sel,
  input logic                 bus_wr,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [DATA_W-1:0]    bus_wdata,
  input logic [3*IRQ_W-1:0]   cfg_q,
  input logic [IRQ_W-1:0]     pend_q,
  input logic [IRQ_W-1:0]     mask_q,
  input logic [IRQ_W-1:0]     s2_q,
  input logic [IRQ_W-1:0]     ipin_out,
  input logic                 irq
);
  logic [IRQ_W-1:0] ackw;
  logic             dout_wr;
  assign ackw    = (bus_sel && bus_wr && bus_addr == ADDR_W'(6)) ? bus_wdata[IRQ_W-1:0] : '0;
  assign dout_wr = bus_sel && bus_wr && bus_addr == ADDR_W'(0);

  p_irq_needs_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != '0));

  p_drive_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_wr |=> $stable(ipin_out));

  for (genvar g = 0; g < IRQ_W; g++) begin : g_chk
    p_forced_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[3*g +: 3] == 3'd3) |=> pend_q[g]);

    p_level_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[3*g +: 3] == 3'd1 && s2_q[g] && !ackw[g]) |=> pend_q[g]);

    p_pending_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[g] && !ackw[g]) |=> pend_q[g]);

    p_ack_clears_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ackw[g] && (cfg_q[3*g +: 3] == 3'd0 || cfg_q[3*g +: 3] == 3'd7)) |=> !pend_q[g]);
  end
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.IRQ_W(IRQ_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .cfg_q(cfg_q), .pend_q(pend_q), .mask_q(mask_q), .s2_q(s2_q),
  .ipin_out(ipin_out), .irq(irq)
);

// File: tb/gpio_irq_port_tb_top.sv
module gpio_irq_port_tb_top;
  localparam int IW = 8, PW = 18, NP = 4, AW = 5, DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  logic [IW-1:0] ipin_in = '0, ipin_out, ipin_oe;
  logic [NP*PW-1:0] ppin_in = '0, ppin_out, ppin_oe;
  logic irq;
  int vectors = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_irq_port #(.IRQ_W(IW), .PLAIN_W(PW), .NUM_PLAIN(NP), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ipin_in(ipin_in), .ipin_out(ipin_out),
    .ipin_oe(ipin_oe), .ppin_in(ppin_in), .ppin_out(ppin_out), .ppin_oe(ppin_oe), .irq(irq));

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bw(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic br(input int a, output logic [DW-1:0] d);
    bus_addr = AW'(a);
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [IW-1:0] expect_after(input int m, input logic [IW-1:0] a, input logic [IW-1:0] b);
    case (m)
      1: return a | b;
      2: return ~a | ~b;
      3: return '1;
      4: return ~a & b;
      5: return a & ~b;
      6: return a ^ b;
      default: return '0;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] r;
    logic [IW-1:0] pa [5];
    logic [IW-1:0] pb [5];
    pa[0] = 8'h00; pb[0] = 8'hFF;
    pa[1] = 8'hFF; pb[1] = 8'h00;
    pa[2] = 8'hA5; pb[2] = 8'h3C;
    pa[3] = 8'h0F; pb[3] = 8'hF0;
    pa[4] = 8'h5A; pb[4] = 8'h5A;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 oe", DW'(ipin_oe), 0);
    chk("R1 plain oe", DW'(ppin_oe != '0), 0);
    chk("R1 irq", DW'(irq), 0);
    for (int a = 0; a < 24; a++) begin br(a, r); chk("R1 regs", r, 0); end

    // R2 drive and enable
    bw(0, 32'hA5); chk("R2 drive", DW'(ipin_out), 32'hA5);
    bw(2, 32'h3C); chk("R2 enable", DW'(ipin_oe), 32'h3C);
    br(0, r); chk("R2 readback drive", r, 32'hA5);
    br(2, r); chk("R2 readback enable", r, 32'h3C);
    bw(1, 32'hFF); br(1, r); chk("R2 din write ignored", r, 0);
    bw(5, 32'hFF); br(5, r); chk("R2 status write ignored", r, 0);

    // R3 synchronizer latency
    @(negedge clk); ipin_in = 8'h81;
    @(negedge clk); br(1, r); chk("R3 one edge", r, 0);
    @(negedge clk); br(1, r); chk("R3 two edges", r, 32'h81);
    @(negedge clk); ipin_in = 8'h00;
    repeat (4) @(negedge clk);

    // R4..R9 mode sweep
    bw(4, 32'hFF);
    for (int m = 0; m < 8; m++) begin
      logic [DW-1:0] cfg;
      cfg = '0;
      for (int i = 0; i < IW; i++) cfg = cfg | (DW'(m) << (3*i));
      bw(3, cfg);
      br(3, r); chk("R4 config readback", r, cfg);
      for (int p = 0; p < 5; p++) begin
        logic [IW-1:0] e;
        @(negedge clk); ipin_in = pa[p];
        repeat (5) @(negedge clk);
        bw(6, 32'hFF);
        br(5, r);
        chk($sformatf("R6 R9 mode%0d just after ack", m), r, (m == 3) ? 32'hFF : 32'h0);
        @(negedge clk); br(5, r);
        e = (m == 1) ? pa[p] : (m == 2) ? ~pa[p] : (m == 3) ? 8'hFF : 8'h00;
        chk($sformatf("R5 mode%0d one cycle after ack", m), r, DW'(e));
        ipin_in = pb[p];
        repeat (4) @(negedge clk);
        e = expect_after(m, pa[p], pb[p]);
        br(5, r);
        chk($sformatf("R7 R4 mode%0d pattern %0d", m, p), r, DW'(e));
        chk($sformatf("R8 irq mode%0d pattern %0d", m, p), DW'(irq), DW'(e != 0));
      end
    end

    // R8 mask, R9 partial ack
    bw(3, 32'h00DB6DB6);
    @(negedge clk); ipin_in = 8'h00;
    repeat (5) @(negedge clk);
    bw(6, 32'hFF);
    ipin_in = 8'hFF;
    repeat (4) @(negedge clk);
    bw(4, 32'h5A); br(5, r); chk("R8 masked status", r, 32'h5A);
    chk("R8 irq with mask", DW'(irq), 1);
    bw(4, 32'h00); br(5, r); chk("R8 all masked", r, 0);
    chk("R8 irq all masked", DW'(irq), 0);
    bw(4, 32'hFF);
    bw(6, 32'h0F); br(5, r); chk("R9 partial ack", r, 32'hF0);
    br(6, r); chk("R9 ack reads zero", r, 0);

    // R10 edge on the acknowledge edge
    bw(3, 32'h00924924);
    @(negedge clk); ipin_in = 8'h00;
    repeat (5) @(negedge clk);
    bw(6, 32'hFF);
    br(5, r); chk("R10 cleared before", r, 0);
    ipin_in = 8'h01;
    @(negedge clk);
    bw(6, 32'h01);
    br(5, r); chk("R10 edge beats ack", r, 32'h01);
    @(negedge clk); ipin_in = 8'h00;
    repeat (6) @(negedge clk);
    br(5, r); chk("R7 held after pin returns", r, 32'h01);

    // R11 plain ports
    for (int k = 0; k < NP; k++) begin
      logic [PW-1:0] dv, ov, iv;
      dv = PW'(32'h15A5A + 32'h1111 * k);
      ov = PW'(32'h2C3C3 ^ (32'h0F0F * k));
      iv = PW'(32'h3FFFF - 32'h0777 * k);
      bw(8 + 4*k, DW'(dv));
      bw(10 + 4*k, DW'(ov));
      chk($sformatf("R11 R2 plain%0d drive", k), DW'(ppin_out[k*PW +: PW]), DW'(dv));
      chk($sformatf("R11 R2 plain%0d enable", k), DW'(ppin_oe[k*PW +: PW]), DW'(ov));
      br(8 + 4*k, r); chk("R11 drive readback", r, DW'(dv));
      br(10 + 4*k, r); chk("R11 enable readback", r, DW'(ov));
      ppin_in[k*PW +: PW] = iv;
      repeat (3) @(negedge clk);
      br(9 + 4*k, r); chk($sformatf("R11 R3 plain%0d din", k), r, DW'(iv));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule